// File: doc/BRIEF.md
# FPU Register Bank and Move Unit

This block holds the floating-point register state of a small FPU: two physical banks of sixteen 32-bit registers and two mode bits. The bank-select bit decides which physical bank is currently the front bank and which is the extended bank. The size bit decides whether moves carry one 32-bit register or an even/odd pair as a 64-bit value. The block executes the operations that need no arithmetic datapath:
- loads and stores with plain, post-increment, pre-decrement and indexed addressing,
- register-to-register moves,
- absolute value and negate on the sign bit,
- load of the constants zero and one,
- raw transfers to and from a 32-bit communication register,
- the two mode swaps.

The decoder supplies a 4-bit operation code, two 4-bit register fields (`fld_n`, `fld_m`), the precision bit, the base general register value and the value of general register 0. In the same cycle, the block answers with a memory request, an updated base value and a communication-register write. Register-file writes, including the data returned by loads, show on the `rf_*` outputs and take effect at the next rising clock edge.

Top module: `fpu_regmove`

## Requirements
- R1: After reset is released, all 32 registers read as zero, and both mode outputs (`mode_bank`, `mode_size`) are 0.
- R2: With `mode_size`=0, a plain load (code 1) requests 32 bits at `base_in`. Its returned `ld_data[31:0]` goes to front register `fld_n`. A plain store (code 4) requests a write at `base_in` with front register `fld_m` in `mem_wdata[31:0]` and zeros above. A move (code 7) copies front register `fld_m` to front register `fld_n`.
- R3: With `mode_size`=1, loads, stores and moves carry a pair as 64 bits. The pair is registers `{fld[3:1],0}` (upper word, bits 63:32) and `{fld[3:1],1}` (lower word). `fld[0]`=0 selects the front bank and `fld[0]`=1 the extended bank, chosen independently for the source and destination of a move.
- R4: A post-increment load (code 2) requests at the old `base_in`. In the same cycle it drives `base_we`=1 and `base_out` = `base_in`+4, or `base_in`+8 when `mode_size`=1.
- R5: A pre-decrement store (code 5) requests at `base_in`−4 (or −8 when `mode_size`=1). It drives that same value on `base_out` with `base_we`=1.
- R6: An indexed load (code 3) or indexed store (code 6) requests at `index_in`+`base_in` and leaves `base_we` at 0.
- R7: The bank swap (code 14) inverts `mode_bank` at the next edge. Data that was in the extended bank is then reached as the front bank, and the reverse.
- R8: The size swap (code 15) inverts `mode_size` at the next edge. No other code changes either mode bit.
- R9: Absolute value (code 8) clears bit 31 of front register `fld_n`, and negate (code 9) inverts that bit. Other bits are unchanged. With `prec`=1 the target is register `fld_n` with bit 0 cleared.
- R10: With `prec`=0, code 10 writes 0x00000000 and code 11 writes 0x3F800000 to front register `fld_n`. With `prec`=1, neither code changes any register.
- R11: Code 12 copies front register `fld_n` unchanged to `comm_out`, with `comm_we`=1. Code 13 copies `comm_in` unchanged into front register `fld_n`.
- R12: For a load, the destination bank and register are fixed when the request is issued. The load data is written at the edge that ends the cycle in which `ld_valid` is 1, and in that cycle the write shows on `rf_we`, `rf_bank`, `rf_idx`, `rf_wide` and `rf_data`. Code 0, or `op_valid`=0, does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| fld_n | input | 4 | Destination / target register field |
| fld_m | input | 4 | Source register field |
| prec | input | 1 | Precision bit, 1 = double |
| base_in | input | 32 | Value of the base general register |
| index_in | input | 32 | Value of general register 0 |
| comm_in | input | 32 | Communication register value |
| ld_valid | input | 1 | Load data returned this cycle |
| ld_data | input | 64 | Returned load data |
| mode_bank | output | 1 | Bank-select mode bit |
| mode_size | output | 1 | Transfer-size mode bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a store |
| mem_wide | output | 1 | Request is 64 bits |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 64 | Store data |
| base_we | output | 1 | Base register update |
| base_out | output | 32 | New base register value |
| comm_we | output | 1 | Communication register write |
| comm_out | output | 32 | Communication register data |
| rf_we | output | 1 | Register file write this cycle |
| rf_bank | output | 1 | Physical bank written |
| rf_idx | output | 4 | Register written (even for 64-bit) |
| rf_wide | output | 1 | Pair write |
| rf_data | output | 64 | Write data |

## Verification
The memory request, base update and communication-register output are combinational. They are due in the same cycle as the operation, so the bench drives each operation at a falling edge and samples one time unit later, before the rising edge. Register-file and mode changes land at the rising edge that ends the operation cycle. Their effect is checked through later stores, moves and transfers, and through the mode outputs sampled in the next operation's cycle. Load data is driven one cycle after the request, and the `rf_*` write is sampled in that cycle, before it is committed.

// File: rtl/fpu_mv_pkg.sv
package fpu_mv_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LD      = 4'd1,
    OP_LD_INC  = 4'd2,
    OP_LD_IDX  = 4'd3,
    OP_ST      = 4'd4,
    OP_ST_DEC  = 4'd5,
    OP_ST_IDX  = 4'd6,
    OP_MOV     = 4'd7,
    OP_ABS     = 4'd8,
    OP_NEG     = 4'd9,
    OP_LDZ     = 4'd10,
    OP_LDONE   = 4'd11,
    OP_TOCOM   = 4'd12,
    OP_FROMCOM = 4'd13,
    OP_BSWAP   = 4'd14,
    OP_SSWAP   = 4'd15
  } mv_op_e;

  typedef struct packed {
    logic is_ld;
    logic is_st;
    logic post_inc;
    logic pre_dec;
    logic indexed;
    logic size_dep;
  } mv_ctl_t;

endpackage

// File: rtl/fpu_mv_decode.sv
module fpu_mv_decode
  import fpu_mv_pkg::*;
(
  input  mv_op_e  op,
  output mv_ctl_t ctl
);

  always_comb begin
    ctl          = '0;
    ctl.is_ld    = (op == OP_LD) || (op == OP_LD_INC) || (op == OP_LD_IDX);
    ctl.is_st    = (op == OP_ST) || (op == OP_ST_DEC) || (op == OP_ST_IDX);
    ctl.post_inc = (op == OP_LD_INC);
    ctl.pre_dec  = (op == OP_ST_DEC);
    ctl.indexed  = (op == OP_LD_IDX) || (op == OP_ST_IDX);
    ctl.size_dep = ctl.is_ld || ctl.is_st || (op == OP_MOV);
  end

endmodule

// File: rtl/fpu_mv_agen.sv
module fpu_mv_agen #(
  parameter int AW = 32
) (
  input  logic          post_inc,
  input  logic          pre_dec,
  input  logic          indexed,
  input  logic          wide,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] base_nxt,
  output logic          base_upd
);

  logic [AW-1:0] step;
  logic [AW-1:0] dec_val;

  assign step    = wide ? AW'(8) : AW'(4);
  assign dec_val = base - step;

  always_comb begin
    addr     = base;
    base_nxt = base;
    base_upd = 1'b0;
    if (indexed) begin
      addr = base + index;
    end
    if (post_inc) begin
      base_nxt = base + step;
      base_upd = 1'b1;
    end
    if (pre_dec) begin
      addr     = dec_val;
      base_nxt = dec_val;
      base_upd = 1'b1;
    end
  end

endmodule

// File: rtl/fpu_mv_regfile.sv
module fpu_mv_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_wide,
  input  logic [2*DW-1:0] wr_data,
  input  logic            rd_bank,
  input  logic [IW-2:0]   rd_pair,
  output logic [DW-1:0]   rd_even,
  output logic [DW-1:0]   rd_odd
);

  logic [DW-1:0] cell_q [2][NREG];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_cell
      logic          en_c;
      logic [DW-1:0] d_c;
      logic [DW-1:0] q_c;

      always_comb begin
        en_c = 1'b0;
        d_c  = wr_data[DW-1:0];
        if (wr_en && (wr_bank == 1'(b))) begin
          if (wr_wide) begin
            en_c = (wr_idx[IW-1:1] == (IW-1)'(r / 2));
            d_c  = ((r % 2) == 0) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
          end else begin
            en_c = (wr_idx == IW'(r));
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_c <= '0;
        end else if (en_c) begin
          q_c <= d_c;
        end
      end

      assign cell_q[b][r] = q_c;
    end
  end

  assign rd_even = cell_q[rd_bank][{rd_pair, 1'b0}];
  assign rd_odd  = cell_q[rd_bank][{rd_pair, 1'b1}];

endmodule

// File: rtl/fpu_regmove.sv
module fpu_regmove
  import fpu_mv_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int AW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [3:0]                op_code,
  input  logic [$clog2(NREG)-1:0]   fld_n,
  input  logic [$clog2(NREG)-1:0]   fld_m,
  input  logic                      prec,
  input  logic [AW-1:0]             base_in,
  input  logic [AW-1:0]             index_in,
  input  logic [DW-1:0]             comm_in,
  input  logic                      ld_valid,
  input  logic [2*DW-1:0]           ld_data,
  output logic                      mode_bank,
  output logic                      mode_size,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic                      mem_wide,
  output logic [AW-1:0]             mem_addr,
  output logic [2*DW-1:0]           mem_wdata,
  output logic                      base_we,
  output logic [AW-1:0]             base_out,
  output logic                      comm_we,
  output logic [DW-1:0]             comm_out,
  output logic                      rf_we,
  output logic                      rf_bank,
  output logic [$clog2(NREG)-1:0]   rf_idx,
  output logic                      rf_wide,
  output logic [2*DW-1:0]           rf_data
);

  localparam int IW = $clog2(NREG);
  localparam int WW = 2 * DW;
  localparam logic [DW-1:0] SIGN_BIT = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] ONE_VAL  = DW'(32'h3F80_0000);

  mv_op_e  op;
  mv_ctl_t ctl;

  assign op = op_valid ? mv_op_e'(op_code) : OP_NOP;

  fpu_mv_decode i_dec (.op(op), .ctl(ctl));

  // mode bits
  logic bank_q, bank_d, size_q, size_d;

  always_comb begin
    bank_d = bank_q ^ (op == OP_BSWAP);
    size_d = size_q ^ (op == OP_SSWAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      size_q <= 1'b0;
    end else begin
      bank_q <= bank_d;
      size_q <= size_d;
    end
  end

  assign mode_bank = bank_q;
  assign mode_size = size_q;

  // field steering
  logic          wide;
  logic          sign_op;
  logic [IW-1:0] src_f;
  logic [IW-1:0] dst_f;
  logic          src_bank;
  logic          dst_bank;
  logic [IW-1:0] dst_idx;
  logic [DW-1:0] rd_even, rd_odd, src_word;

  assign wide    = size_q && ctl.size_dep;
  assign sign_op = (op == OP_ABS) || (op == OP_NEG);

  always_comb begin
    src_f = (ctl.is_st || op == OP_MOV) ? fld_m : fld_n;
    dst_f = fld_n;
    if (sign_op && prec) begin
      src_f[0] = 1'b0;
      dst_f[0] = 1'b0;
    end
  end

  assign src_bank = (wide && src_f[0]) ^ bank_q;
  assign dst_bank = (wide && dst_f[0]) ^ bank_q;
  assign dst_idx  = wide ? {dst_f[IW-1:1], 1'b0} : dst_f;
  assign src_word = src_f[0] ? rd_odd : rd_even;

  // address generation
  fpu_mv_agen #(.AW(AW)) i_agen (
    .post_inc (ctl.post_inc),
    .pre_dec  (ctl.pre_dec),
    .indexed  (ctl.indexed),
    .wide     (wide),
    .base     (base_in),
    .index    (index_in),
    .addr     (mem_addr),
    .base_nxt (base_out),
    .base_upd (base_we)
  );

  assign mem_req   = ctl.is_ld || ctl.is_st;
  assign mem_we    = ctl.is_st;
  assign mem_wide  = wide;
  assign mem_wdata = !ctl.is_st ? '0 :
                     wide       ? {rd_even, rd_odd} : {{DW{1'b0}}, src_word};

  assign comm_we  = (op == OP_TOCOM);
  assign comm_out = comm_we ? src_word : '0;

  // operation-side write
  logic          op_we;
  logic [WW-1:0] op_data;

  always_comb begin
    op_we   = 1'b0;
    op_data = '0;
    case (op)
      OP_MOV: begin
        op_we   = 1'b1;
        op_data = wide ? {rd_even, rd_odd} : {{DW{1'b0}}, src_word};
      end
      OP_ABS: begin
        op_we   = 1'b1;
        op_data = {{DW{1'b0}}, src_word & ~SIGN_BIT};
      end
      OP_NEG: begin
        op_we   = 1'b1;
        op_data = {{DW{1'b0}}, src_word ^ SIGN_BIT};
      end
      OP_LDZ:     op_we = !prec;
      OP_LDONE: begin
        op_we   = !prec;
        op_data = {{DW{1'b0}}, ONE_VAL};
      end
      OP_FROMCOM: begin
        op_we   = 1'b1;
        op_data = {{DW{1'b0}}, comm_in};
      end
      default: ;
    endcase
  end

  // pending load destination
  logic          pend_v_q, pend_v_d;
  logic          pend_bank_q, pend_bank_d;
  logic [IW-1:0] pend_idx_q, pend_idx_d;
  logic          pend_wide_q, pend_wide_d;
  logic          ld_fire;

  assign ld_fire = ld_valid && pend_v_q;

  always_comb begin
    pend_v_d    = pend_v_q;
    pend_bank_d = pend_bank_q;
    pend_idx_d  = pend_idx_q;
    pend_wide_d = pend_wide_q;
    if (ctl.is_ld) begin
      pend_v_d    = 1'b1;
      pend_bank_d = dst_bank;
      pend_idx_d  = dst_idx;
      pend_wide_d = wide;
    end else if (ld_fire) begin
      pend_v_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_bank_q <= 1'b0;
      pend_idx_q  <= '0;
      pend_wide_q <= 1'b0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_bank_q <= pend_bank_d;
      pend_idx_q  <= pend_idx_d;
      pend_wide_q <= pend_wide_d;
    end
  end

  // write port select: returning load wins
  always_comb begin
    if (ld_fire) begin
      rf_we   = 1'b1;
      rf_bank = pend_bank_q;
      rf_idx  = pend_idx_q;
      rf_wide = pend_wide_q;
      rf_data = pend_wide_q ? ld_data : {{DW{1'b0}}, ld_data[DW-1:0]};
    end else begin
      rf_we   = op_we;
      rf_bank = dst_bank;
      rf_idx  = dst_idx;
      rf_wide = wide && (op == OP_MOV);
      rf_data = op_data;
    end
  end

  fpu_mv_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) i_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_we),
    .wr_bank (rf_bank),
    .wr_idx  (rf_idx),
    .wr_wide (rf_wide),
    .wr_data (rf_data),
    .rd_bank (src_bank),
    .rd_pair (src_f[IW-1:1]),
    .rd_even (rd_even),
    .rd_odd  (rd_odd)
  );

  // assertions
  AST_WIDE_EVEN_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wide) |-> !rf_idx[0]); // R3
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LD_INC) |-> (base_we && (base_out - mem_addr) == (size_q ? AW'(8) : AW'(4)))); // R4
  AST_PREDEC_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ST_DEC) |-> (base_we && base_out == mem_addr && (base_in - mem_addr) == (size_q ? AW'(8) : AW'(4)))); // R5
  AST_INDEXED_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LD_IDX || op == OP_ST_IDX) |-> (!base_we && mem_addr == base_in + index_in)); // R6
  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BSWAP) |=> (mode_bank != $past(mode_bank))); // R7
  AST_SIZE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SSWAP) |=> (mode_size != $past(mode_size))); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_BSWAP && op != OP_SSWAP) |=> ($stable(mode_bank) && $stable(mode_size))); // R8
  AST_CONST_PREC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_LDZ || op == OP_LDONE) && prec && !ld_valid) |-> !rf_we); // R10

endmodule

// File: tb/test_fpu_regmove.sv
module test_fpu_regmove;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [3:0]  fld_n, fld_m;
  logic        prec;
  logic [31:0] base_in, index_in, comm_in;
  logic        ld_valid;
  logic [63:0] ld_data;
  logic        mode_bank, mode_size, mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        base_we;
  logic [31:0] base_out;
  logic        comm_we;
  logic [31:0] comm_out;
  logic        rf_we, rf_bank, rf_wide;
  logic [3:0]  rf_idx;
  logic [63:0] rf_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] ref_rf [0:1][0:15];
  logic        ref_bank, ref_size;

  fpu_regmove i_fpu_regmove (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .fld_n(fld_n), .fld_m(fld_m), .prec(prec), .base_in(base_in),
    .index_in(index_in), .comm_in(comm_in), .ld_valid(ld_valid),
    .ld_data(ld_data), .mode_bank(mode_bank), .mode_size(mode_size),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .base_we(base_we),
    .base_out(base_out), .comm_we(comm_we), .comm_out(comm_out),
    .rf_we(rf_we), .rf_bank(rf_bank), .rf_idx(rf_idx), .rf_wide(rf_wide),
    .rf_data(rf_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic phys(logic ext);
    return ext ^ ref_bank;
  endfunction

  function automatic logic [63:0] pair_val(logic ext, int p);
    return {ref_rf[phys(ext)][2*p], ref_rf[phys(ext)][2*p+1]};
  endfunction

  // One operation; for loads, return data in the following cycle.
  task automatic run_op(int op, int n, int m, bit pr, logic [31:0] base,
                        logic [31:0] idx, logic [31:0] cin, logic [63:0] ldv);
    bit          wide;
    bit          is_ld, is_st;
    logic [31:0] step, exp_addr, exp_base;
    bit          exp_bwe;
    string       areq;
    logic [63:0] wval;
    bit          do_wr;
    logic        wb;
    int          wi;
    bit          wwide;
    int          t;
    logic        pb;
    int          pi;

    @(negedge clk);
    op_valid = 1'b1; op_code = 4'(op); fld_n = 4'(n); fld_m = 4'(m);
    prec = pr; base_in = base; index_in = idx; comm_in = cin; ld_valid = 1'b0;
    #1;
    chk("R7", "mode_bank", {63'd0, mode_bank}, {63'd0, ref_bank});
    chk("R8", "mode_size", {63'd0, mode_size}, {63'd0, ref_size});

    is_ld = (op >= 1 && op <= 3);
    is_st = (op >= 4 && op <= 6);
    wide  = ref_size && (is_ld || is_st || op == 7);
    step  = wide ? 32'd8 : 32'd4;
    exp_addr = base; exp_base = base; exp_bwe = 1'b0; areq = wide ? "R3" : "R2";
    if (op == 2) begin exp_base = base + step; exp_bwe = 1'b1; areq = "R4"; end
    if (op == 5) begin exp_addr = base - step; exp_base = exp_addr; exp_bwe = 1'b1; areq = "R5"; end
    if (op == 3 || op == 6) begin exp_addr = base + idx; areq = "R6"; end

    chk("R12", "mem_req", {63'd0, mem_req}, {63'd0, (is_ld || is_st)});
    chk(areq, "base_we", {63'd0, base_we}, {63'd0, exp_bwe});
    if (is_ld || is_st) begin
      chk(areq, "mem_addr", {32'd0, mem_addr}, {32'd0, exp_addr});
      chk(areq, "mem_wide", {63'd0, mem_wide}, {63'd0, wide});
      chk(areq, "mem_we", {63'd0, mem_we}, {63'd0, is_st});
      if (exp_bwe) chk(areq, "base_out", {32'd0, base_out}, {32'd0, exp_base});
    end
    if (is_st) begin
      wval = wide ? pair_val(m[0], m / 2) : {32'd0, ref_rf[phys(1'b0)][m]};
      chk(wide ? "R3" : "R2", "mem_wdata", mem_wdata, wval);
    end
    if (op == 12) begin
      chk("R11", "comm_we", {63'd0, comm_we}, 64'd1);
      chk("R11", "comm_out", {32'd0, comm_out}, {32'd0, ref_rf[phys(1'b0)][n]});
    end
    if ((op == 10 || op == 11) && pr) chk("R10", "rf_we quiet", {63'd0, rf_we}, 64'd0);
    if (op == 0) chk("R12", "nop rf_we", {63'd0, rf_we}, 64'd0);

    // expected register write of this op
    do_wr = 1'b0; wb = phys(1'b0); wi = n; wwide = 1'b0; wval = '0;
    case (op)
      7: begin
        do_wr = 1'b1;
        if (wide) begin
          wwide = 1'b1; wb = phys(n[0]); wi = (n / 2) * 2; wval = pair_val(m[0], m / 2);
        end else wval = {32'd0, ref_rf[phys(1'b0)][m]};
      end
      8, 9: begin
        t = pr ? (n & 14) : n; wi = t; do_wr = 1'b1;
        wval = {32'd0, (op == 8) ? (ref_rf[phys(1'b0)][t] & 32'h7FFF_FFFF)
                                 : (ref_rf[phys(1'b0)][t] ^ 32'h8000_0000)};
      end
      10: begin do_wr = !pr; wval = 64'd0; end
      11: begin do_wr = !pr; wval = 64'h3F80_0000; end
      13: begin do_wr = 1'b1; wval = {32'd0, cin}; end
      default: ;
    endcase
    if (do_wr) begin
      chk((op == 7) ? (wide ? "R3" : "R2") : (op >= 10 && op <= 11) ? "R10" :
          (op == 13) ? "R11" : "R9", "rf_data", rf_data, wval);
    end

    pb = phys(wide ? n[0] : 1'b0);
    pi = wide ? (n / 2) * 2 : n;

    @(posedge clk);
    if (do_wr) begin
      if (wwide) begin
        ref_rf[wb][wi] = wval[63:32]; ref_rf[wb][wi+1] = wval[31:0];
      end else ref_rf[wb][wi] = wval[31:0];
    end
    if (op == 14) ref_bank = ~ref_bank;
    if (op == 15) ref_size = ~ref_size;

    if (is_ld) begin
      @(negedge clk);
      op_valid = 1'b0; ld_valid = 1'b1; ld_data = ldv;
      #1;
      chk("R12", "load rf_we", {63'd0, rf_we}, 64'd1);
      chk("R12", "load rf_bank", {63'd0, rf_bank}, {63'd0, pb});
      chk("R12", "load rf_idx", {60'd0, rf_idx}, 64'(pi));
      chk(wide ? "R3" : "R2", "load rf_data", rf_data, wide ? ldv : {32'd0, ldv[31:0]});
      @(posedge clk);
      if (wide) begin
        ref_rf[pb][pi] = ldv[63:32]; ref_rf[pb][pi+1] = ldv[31:0];
      end else ref_rf[pb][pi] = ldv[31:0];
      @(negedge clk);
      ld_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F2E_3D4C;
    void'($urandom(seed));
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; fld_n = '0; fld_m = '0;
    prec = 1'b0; base_in = '0; index_in = '0; comm_in = '0;
    ld_valid = 1'b0; ld_data = '0;
    for (int b = 0; b < 2; b++) for (int r = 0; r < 16; r++) ref_rf[b][r] = '0;
    ref_bank = 1'b0; ref_size = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "reset mode_bank", {63'd0, mode_bank}, 64'd0);
    chk("R1", "reset mode_size", {63'd0, mode_size}, 64'd0);
    chk("R1", "reset rf_we", {63'd0, rf_we}, 64'd0);
    // R1: every front register reads zero through a store
    for (int r = 0; r < 16; r++) run_op(4, 0, r, 0, 32'h40, 0, 0, 0);

    // directed: R11 round trip, R2/R4 single loads
    run_op(13, 2, 0, 0, 0, 0, 32'hA5A5_5A5A, 0);
    run_op(12, 2, 0, 0, 0, 0, 0, 0);
    run_op(2, 4, 0, 0, 32'h100, 0, 0, 64'h1111_2222_3333_4444);
    run_op(4, 0, 4, 0, 32'h80, 0, 0, 0);
    // R3 wide mode: front pair 3 and extended pair 3
    run_op(15, 0, 0, 0, 0, 0, 0, 0);
    run_op(1, 6, 0, 0, 32'h200, 0, 0, 64'hC0DE_0001_C0DE_0002);
    run_op(2, 7, 0, 0, 32'h300, 0, 0, 64'hBEEF_0003_BEEF_0004);
    run_op(4, 0, 6, 0, 32'h10, 0, 0, 0);
    run_op(5, 0, 7, 0, 32'h200, 0, 0, 0);
    run_op(7, 1, 6, 0, 0, 0, 0, 0);
    run_op(6, 0, 1, 0, 32'h20, 32'h8, 0, 0);
    // R7: swap banks, the former extended pair appears at front
    run_op(14, 0, 0, 0, 0, 0, 0, 0);
    run_op(4, 0, 6, 0, 32'h10, 0, 0, 0);
    run_op(4, 0, 7, 0, 32'h10, 0, 0, 0);
    run_op(15, 0, 0, 0, 0, 0, 0, 0);
    // R9 with prec=1 targets even register; R10 quiet with prec=1
    run_op(9, 5, 0, 1, 0, 0, 0, 0);
    run_op(4, 0, 4, 0, 0, 0, 0, 0);
    run_op(8, 7, 0, 0, 0, 0, 0, 0);
    run_op(10, 6, 0, 1, 0, 0, 0, 0);
    run_op(4, 0, 6, 0, 0, 0, 0, 0);
    run_op(11, 9, 0, 0, 0, 0, 0, 0);
    run_op(4, 0, 9, 0, 0, 0, 0, 0);
    run_op(0, 3, 3, 0, 0, 0, 0, 0);

    // constrained random
    for (int k = 0; k < 600; k++) begin
      run_op(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
             int'($urandom_range(15, 0)), 1'($urandom_range(1, 0)),
             {$urandom_range(32'hFFFF, 32'h10), 2'b00}, {$urandom_range(255, 0), 2'b00},
             $urandom(), {$urandom(), $urandom()});
    end
    // final sweep of all registers in both banks through stores
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 16; r++) run_op(4, 0, r, 0, 32'h40, 0, 0, 0);
      run_op(14, 0, 0, 0, 0, 0, 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule